// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block gathers interrupt causes from internal sources into a 32-bit host status word, gates them with an enable mask, and drives one host interrupt line. A second status word tracks events from the DMA engines. Its bits are folded into three summary bits of the main status word. Causes arrive as single-cycle pulses. The host reads and writes the four registers through a simple word-wide port. It clears status bits by writing ones to them.

To reduce the host interrupt rate, the block delays the line by a programmable interval counted in 32-microsecond ticks. The parameter `TICK_CYCLES` sets how many clocks make one tick. The interval starts at the first pending enabled cause. A high-priority receive event skips the wait. An interval of zero skips it for every cause.

Top module: `intr_coalesce_ctrl`

## Requirements
- R1: A pulse on a main cause input sets its main status bit on the next clock edge: alive bit 0, wake bit 1, over-temperature bit 6, RF-kill bit 7, firmware error bit 25. Main status bits with no source and no summary role read 0.
- R2: Register map (byte address on `addr_i`): 0x0 main status, 0x4 enable mask, 0x8 DMA status, 0xC coalescing interval. Reads are combinational from `addr_i`; unmapped addresses read 0. A write to either status register clears each bit written as 1 and leaves each bit written as 0.
- R3: DMA status holds error at bit 31, high-priority receive at bit 30, receive channels 0/1 at bits 16/17 and transmit channels 0/1 at bits 0/1, each set by its input pulse.
- R4: Main status bit 29 reflects DMA bit 31; main bit 31 is the OR of DMA bits 30, 17 and 16; main bit 27 is the OR of DMA bits 1 and 0. A host write to main bits 27, 29 or 31 has no effect; those bits clear only through the DMA status register.
- R5: If a cause pulse and a host write-1-to-clear reach the same bit in the same cycle, the bit ends up set.
- R6: A status bit whose enable mask bit is 0 never raises `irq_o`.
- R7: With an interval N of at least 1, `irq_o` rises N*TICK_CYCLES+1 clock edges after the edge that captured the first enabled cause.
- R8: With an interval of 0, `irq_o` rises on the edge after the enabled cause is captured.
- R9: When DMA bit 30 is set and mask bit 31 is enabled, `irq_o` rises on the next edge, whatever the interval.
- R10: Once no enabled cause is pending, `irq_o` falls on the next edge and the timer is cancelled. A later cause waits the full interval again.
- R11: The enable mask (32 bits) and the interval (IVL_W bits, zero-extended) read back what was last written.
- R12: After reset, every register reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Host write strobe |
| addr_i | input | AW | Host byte address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data for `addr_i` |
| evt_alive_i | input | 1 | Alive cause pulse |
| evt_wake_i | input | 1 | Wake cause pulse |
| evt_temp_i | input | 1 | Over-temperature cause pulse |
| evt_rfkill_i | input | 1 | RF-kill cause pulse |
| evt_fw_err_i | input | 1 | Firmware error cause pulse |
| dma_err_i | input | 1 | DMA error pulse |
| dma_hipri_i | input | 1 | High-priority receive pulse |
| dma_rx_i | input | 2 | Receive channel pulses |
| dma_tx_i | input | 2 | Transmit channel pulses |
| irq_o | output | 1 | Host interrupt line |

## Verification
Two functions can act on one status bit in the same cycle: a hardware set and a host write-1-to-clear. The bench raises a cause pulse on the same clock edge that carries a clear of that bit. It then reads the status back and expects the bit to be set. The second pairing is an expiring interval and the host clearing the last pending cause. The bench clears the cause partway through an interval and expects the next cause to wait a full new interval, rather than fire on the time left from the old one.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned DW = 32;

  // main status bit positions
  localparam int unsigned M_ALIVE  = 0;
  localparam int unsigned M_WAKE   = 1;
  localparam int unsigned M_TEMP   = 6;
  localparam int unsigned M_RFKILL = 7;
  localparam int unsigned M_TXSUM  = 27;
  localparam int unsigned M_FWERR  = 25;
  localparam int unsigned M_ERRSUM = 29;
  localparam int unsigned M_RXSUM  = 31;

  // DMA status bit positions
  localparam int unsigned D_TX0   = 0;
  localparam int unsigned D_TX1   = 1;
  localparam int unsigned D_RX0   = 16;
  localparam int unsigned D_RX1   = 17;
  localparam int unsigned D_HIPRI = 30;
  localparam int unsigned D_ERR   = 31;

  localparam logic [DW-1:0] MAIN_IMPL = (DW'(1) << M_ALIVE) | (DW'(1) << M_WAKE) |
                                        (DW'(1) << M_TEMP)  | (DW'(1) << M_RFKILL) |
                                        (DW'(1) << M_FWERR);
  localparam logic [DW-1:0] DMA_IMPL  = (DW'(1) << D_TX0) | (DW'(1) << D_TX1) |
                                        (DW'(1) << D_RX0) | (DW'(1) << D_RX1) |
                                        (DW'(1) << D_HIPRI) | (DW'(1) << D_ERR);

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_MASK = 2'd1,
    SEL_DMA  = 2'd2,
    SEL_IVL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_w1c_reg.sv
module intr_w1c_reg #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ((q & ~clr_i) | set_i) & IMPL;  // set beats clear
  end

  assign q_o = q;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & IMPL) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/intr_coalesce_timer.sv
module intr_coalesce_timer #(
  parameter int unsigned TICK_CYCLES = 3200,
  parameter int unsigned IVL_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pending_i,
  input  logic             urgent_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             fire_o
);
  localparam int unsigned PW = $clog2(TICK_CYCLES + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0]    pre_q;
  logic [IVL_W-1:0] tick_q;
  logic             armed_q, fire_q;
  logic             pre_wrap, tick_done;

  assign pre_wrap  = (pre_q == PRE_LAST);
  assign tick_done = ({1'b0, tick_q} + 1'b1) >= {1'b0, interval_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0; tick_q <= '0; armed_q <= 1'b0; fire_q <= 1'b0;
    end else if (!pending_i) begin
      pre_q <= '0; tick_q <= '0; armed_q <= 1'b0; fire_q <= 1'b0;
    end else if (!fire_q) begin
      if (urgent_i || interval_i == '0) begin
        fire_q <= 1'b1;
      end else if (!armed_q) begin
        armed_q <= 1'b1; pre_q <= '0; tick_q <= '0;
      end else if (pre_wrap) begin
        pre_q <= '0;
        if (tick_done) fire_q <= 1'b1;
        else           tick_q <= tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign fire_o = fire_q;

  assert_zero_ivl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i && interval_i == '0) |=> fire_o);
  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i && urgent_i) |=> fire_o);
  assert_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_i |=> !fire_o);
  assert_fire_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_o) |-> $past(pending_i));
endmodule

// File: rtl/intr_coalesce_ctrl.sv
module intr_coalesce_ctrl
  import intr_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 3200,
  parameter int unsigned IVL_W       = 16,
  parameter int unsigned AW          = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          evt_alive_i,
  input  logic          evt_wake_i,
  input  logic          evt_temp_i,
  input  logic          evt_rfkill_i,
  input  logic          evt_fw_err_i,
  input  logic          dma_err_i,
  input  logic          dma_hipri_i,
  input  logic [1:0]    dma_rx_i,
  input  logic [1:0]    dma_tx_i,
  output logic          irq_o
);
  logic [DW-1:0]    main_set, dma_set, main_clr, dma_clr;
  logic [DW-1:0]    main_q, dma_q, main_word, mask_q;
  logic [IVL_W-1:0] ivl_q;
  logic             sel_ok, pending, urgent;
  reg_sel_e         sel;

  assign sel    = reg_sel_e'(addr_i[3:2]);
  assign sel_ok = (addr_i[1:0] == 2'b00) && (addr_i >> 4) == '0;

  always_comb begin
    main_set = '0;
    main_set[M_ALIVE]  = evt_alive_i;
    main_set[M_WAKE]   = evt_wake_i;
    main_set[M_TEMP]   = evt_temp_i;
    main_set[M_RFKILL] = evt_rfkill_i;
    main_set[M_FWERR]  = evt_fw_err_i;
    dma_set = '0;
    dma_set[D_ERR]   = dma_err_i;
    dma_set[D_HIPRI] = dma_hipri_i;
    dma_set[D_RX0]   = dma_rx_i[0];
    dma_set[D_RX1]   = dma_rx_i[1];
    dma_set[D_TX0]   = dma_tx_i[0];
    dma_set[D_TX1]   = dma_tx_i[1];
  end

  assign main_clr = (we_i && sel_ok && sel == SEL_MAIN) ? wdata_i : '0;
  assign dma_clr  = (we_i && sel_ok && sel == SEL_DMA)  ? wdata_i : '0;

  intr_w1c_reg #(.W(DW), .IMPL(MAIN_IMPL)) u_main (
    .clk_i, .rst_ni, .set_i(main_set), .clr_i(main_clr), .q_o(main_q));

  intr_w1c_reg #(.W(DW), .IMPL(DMA_IMPL)) u_dma (
    .clk_i, .rst_ni, .set_i(dma_set), .clr_i(dma_clr), .q_o(dma_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ivl_q  <= '0;
    end else if (we_i && sel_ok) begin
      if (sel == SEL_MASK) mask_q <= wdata_i;
      if (sel == SEL_IVL)  ivl_q  <= wdata_i[IVL_W-1:0];
    end
  end

  // summary bits are live views of the DMA word
  always_comb begin
    main_word = main_q;
    main_word[M_ERRSUM] = dma_q[D_ERR];
    main_word[M_RXSUM]  = dma_q[D_HIPRI] | dma_q[D_RX1] | dma_q[D_RX0];
    main_word[M_TXSUM]  = dma_q[D_TX1] | dma_q[D_TX0];
  end

  assign pending = |(main_word & mask_q);
  assign urgent  = dma_q[D_HIPRI] & mask_q[M_RXSUM];

  intr_coalesce_timer #(.TICK_CYCLES(TICK_CYCLES), .IVL_W(IVL_W)) u_timer (
    .clk_i, .rst_ni, .pending_i(pending), .urgent_i(urgent),
    .interval_i(ivl_q), .fire_o(irq_o));

  always_comb begin
    rdata_o = '0;
    if (sel_ok) begin
      unique case (sel)
        SEL_MAIN: rdata_o = main_word;
        SEL_MASK: rdata_o = mask_q;
        SEL_DMA:  rdata_o = dma_q;
        SEL_IVL:  rdata_o = 32'(ivl_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assert_err_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_err_i |=> main_word[M_ERRSUM]);
  assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
endmodule

// File: tb/intr_coalesce_ctrl_tb.sv
module intr_coalesce_ctrl_tb_top;
  localparam int unsigned T = 4;

  logic        clk = 1'b0, rst_ni = 1'b0, we = 1'b0, irq;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [10:0] ev = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  intr_coalesce_ctrl #(.TICK_CYCLES(T), .IVL_W(16), .AW(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_alive_i(ev[0]), .evt_wake_i(ev[1]), .evt_temp_i(ev[2]),
    .evt_rfkill_i(ev[3]), .evt_fw_err_i(ev[4]), .dma_err_i(ev[5]),
    .dma_hipri_i(ev[6]), .dma_rx_i(ev[8:7]), .dma_tx_i(ev[10:9]), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic [10:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic latency(output int c);
    c = 0;
    while (!irq && c < 300) begin @(negedge clk); c++; end
  endtask

  task automatic clean();
    wr(4'h4, 32'h0); wr(4'h0, '1); wr(4'h8, '1); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 16; a += 4) begin rd(4'(a), d); check("R12 reg", d, 0); end
    check("R12 irq", 32'(irq), 0);
  endtask

  task automatic t_causes();
    logic [31:0] d;
    pulse(11'h01f); rd(4'h0, d);
    check("R1 main bits", d, 32'h0200_00c3);
    wr(4'h0, 32'h0000_0041); rd(4'h0, d);
    check("R2 w1c", d, 32'h0200_0082);
    clean();
  endtask

  task automatic t_dma();
    logic [31:0] d;
    pulse(11'h7e0); rd(4'h8, d);
    check("R3 dma bits", d, 32'hc003_0003);
    rd(4'h0, d); check("R4 summary", d, 32'ha800_0000);
    wr(4'h0, 32'ha800_0000); rd(4'h0, d);
    check("R4 main write ignored", d, 32'ha800_0000);
    wr(4'h8, 32'h4003_0000); rd(4'h0, d);
    check("R4 rx cleared", d, 32'h2800_0000);
    clean();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(11'h001);
    @(negedge clk); ev = 11'h001; we = 1'b1; addr = 4'h0; wdata = 32'h1;
    @(negedge clk); ev = '0; we = 1'b0;
    rd(4'h0, d); check("R5 set wins", d & 32'h1, 32'h1);
    clean();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'hC, 0); wr(4'h4, 32'h1);
    pulse(11'h002);
    repeat (20) @(negedge clk);
    check("R6 masked quiet", 32'(irq), 0);
    rd(4'h0, d); check("R6 status kept", d, 32'h2);
    clean();
  endtask

  task automatic t_coalesce();
    int c;
    wr(4'hC, 3); wr(4'h4, 32'h1);
    pulse(11'h001); latency(c);
    check("R7 delay", 32'(c), 3 * T + 1);
    wr(4'h0, 32'h1); @(negedge clk);
    check("R10 irq drop", 32'(irq), 0);
    pulse(11'h001); repeat (6) @(negedge clk);
    wr(4'h0, 32'h1); repeat (3) @(negedge clk);
    pulse(11'h001); latency(c);
    check("R10 restart", 32'(c), 3 * T + 1);
    clean();
    wr(4'hC, 1); wr(4'h4, 32'h8000_0000);
    pulse(11'h080); latency(c);
    check("R4 R7 rx summary delay", 32'(c), T + 1);
    clean();
  endtask

  task automatic t_zero();
    int c;
    wr(4'hC, 0); wr(4'h4, 32'h0200_0000);
    pulse(11'h010); latency(c);
    check("R8 immediate", 32'(c), 1);
    clean();
  endtask

  task automatic t_hipri();
    int c;
    wr(4'hC, 5); wr(4'h4, 32'h8000_0000);
    pulse(11'h040); latency(c);
    check("R9 bypass", 32'(c), 1);
    clean();
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'h4, 32'hdead_beef); rd(4'h4, d); check("R11 mask", d, 32'hdead_beef);
    wr(4'hC, 32'hffff_1234); rd(4'hC, d); check("R11 ivl", d, 32'h0000_1234);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_causes();
    t_dma();
    t_collide();
    t_mask();
    t_coalesce();
    t_zero();
    t_hipri();
    t_regs();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule